// File: doc/BRIEF.md
# Buffered Prescaled Timer Time Base

This block is the counting core of a general-purpose hardware timer. A prescaler divides a stream of qualified count ticks by a programmable factor. The divided ticks drive a main counter that runs up, down or up-and-down (center-aligned) against a reload limit. Each time the counter wraps, an optional repetition divider decides whether the wrap becomes an update event. An update event produces a one-cycle pulse, sets a sticky flag and, if enabled, raises an interrupt request.

Software reaches the block through a flat register port: a write strobe with an address and data, and a combinational read mux. The prescaler and reload values are double-buffered. A written value sits in a buffer register and moves into the active copy only on an update event, so a running period is never split between two settings. Buffering of the reload value can be turned off, in which case a new limit applies at once. A software update request restarts the whole time base on demand and loads every active copy.

Top module: `tmr_timebase`

## Requirements
- R1: After reset every register reads 0 at all six addresses (0 control, 1 prescaler, 2 counter, 3 reload, 4 repetition, 5 flag). The count, flag, interrupt request and update pulse are all 0.
- R2: The counter, prescaler and update pulse do not advance while control bit 0 (enable) is 0 or while `tick_en` is low.
- R3: With an active prescaler value P, the counter moves one step per P+1 qualified ticks, starting from a prescaler phase of 0 after a software update.
- R4: With control bits [2:1] = 00 (and also 11), the counter counts 0 up to the reload value L. On the following step it returns to 0 and wraps.
- R5: With control bits [2:1] = 01, the counter counts down from L to 0. On the following step it reloads L and wraps.
- R6: With control bits [2:1] = 10, the counter runs 0 up to L, then back down to 0, and repeats. It wraps on the step that leaves L and on the step that leaves 0 while counting down.
- R7: A value written to the prescaler (address 1) is used only after the next update event.
- R8: With control bit 3 set, a written reload value (address 3) is used only after the next update event. With control bit 3 clear, it is used immediately, in the current period.
- R9: Each update event sets the flag, read as bit 0 of address 5. Only a write to address 5 with data bit 0 set clears it, and a simultaneous update wins over the clear.
- R10: `irq` is high exactly when the flag is set and control bit 4 is set.
- R11: With a repetition value N (address 4), only one wrap in every N+1 produces an update event.
- R12: A pulse on `sw_update` restarts the prescaler, sets the count to 0 (or to the reload value in down mode), loads the active prescaler, reload and repetition values, and produces an update pulse in the next cycle.
- R13: A write to address 2 loads the counter directly, and the count then continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Qualifies a count tick in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| sw_update | input | 1 | Software update request |
| update_evt | output | 1 | One-cycle update event pulse |
| update_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Flag masked by the interrupt enable |
| count | output | CNT_W | Current counter value |

## Verification
The hardest case to reach is a buffered setting that changes while a period is in flight. The old value must stay in use up to the wrap and the new one must apply from the very next step. The bench reaches this case by stopping `tick_en`, writing the new prescaler or reload value mid-period, and then resuming for an exact number of ticks. This lets it check the count before and after the wrap. Repetition and center-aligned phasing are covered through table vectors whose tick counts end partway through a period. The expected count and number of update pulses are worked out per vector.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] RA_PSC    = 3'd1;
   localparam logic [ADDR_W-1:0] RA_CNT    = 3'd2;
   localparam logic [ADDR_W-1:0] RA_RELOAD = 3'd3;
   localparam logic [ADDR_W-1:0] RA_REP    = 3'd4;
   localparam logic [ADDR_W-1:0] RA_FLAG   = 3'd5;

   typedef enum logic [1:0] {
      CM_UP     = 2'b00,
      CM_DOWN   = 2'b01,
      CM_CENTER = 2'b10,
      CM_UP_ALT = 2'b11
   } cnt_mode_e;

   localparam int CTRL_W = 5;

   // bit 0 enable, [2:1] mode, bit 3 reload buffering, bit 4 irq enable
   typedef struct packed {
      logic      ie;
      logic      preload;
      cnt_mode_e mode;
      logic      en;
   } ctrl_t;
endpackage

// File: rtl/tmr_psc_div.sv
`timescale 1ns/1ps
module tmr_psc_div #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;
   logic             at_end;

   assign at_end = (phase_q >= div);
   assign tick   = run && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (run)     phase_q <= at_end ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/tmr_rep_div.sv
`timescale 1ns/1ps
module tmr_rep_div #(
   parameter int REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   input  logic             reload,
   input  logic [REP_W-1:0] rep_val,
   output logic             last
);
   logic [REP_W-1:0] left_q;

   assign last = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (reload) left_q <= rep_val;
      else if (wrap)   left_q <= last ? rep_val : left_q - 1'b1;
   end
endmodule

// File: rtl/tmr_cnt_core.sv
`timescale 1ns/1ps
module tmr_cnt_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] refill,
   input  logic             init,
   input  logic [CNT_W-1:0] init_val,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             down_q;
   logic             hit;
   logic             nxt_down;
   logic [CNT_W-1:0] nxt;

   // wrap decision and direction: independent of refill
   always_comb begin
      hit      = 1'b0;
      nxt_down = down_q;
      case (mode)
         CM_DOWN:   hit = (count == '0);
         CM_CENTER: begin
            if (!down_q) begin
               hit = (count >= limit);
               if (hit) nxt_down = 1'b1;
            end else begin
               hit = (count == '0);
               if (hit) nxt_down = 1'b0;
            end
         end
         default:   hit = (count >= limit);
      endcase
   end

   always_comb begin
      case (mode)
         CM_DOWN:   nxt = hit ? refill : count - ONE;
         CM_CENTER: begin
            if (!down_q) nxt = hit ? ((limit == '0) ? '0 : limit - ONE) : count + ONE;
            else         nxt = hit ? ((limit == '0) ? '0 : ONE)         : count - ONE;
         end
         default:   nxt = hit ? '0 : count + ONE;
      endcase
   end

   assign wrap = step && hit && !init && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         down_q <= 1'b0;
      end else if (init) begin
         count  <= init_val;
         down_q <= 1'b0;
      end else if (load) begin
         count  <= load_val;
      end else if (step) begin
         count  <= nxt;
         down_q <= nxt_down;
      end
   end
endmodule

// File: rtl/tmr_timebase.sv
`timescale 1ns/1ps
module tmr_timebase
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16,
   parameter int REP_W  = 8,
   parameter bit REP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              sw_update,
   output logic              update_evt,
   output logic              update_flag,
   output logic              irq,
   output logic [CNT_W-1:0]  count
);
   if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_cnt_w
      $error("tmr_timebase: CNT_W must lie in 5..32");
   end
   if (PSC_W < 1 || PSC_W > CNT_W) begin : g_bad_psc_w
      $error("tmr_timebase: PSC_W must lie in 1..CNT_W");
   end
   if (REP_W < 1 || REP_W > CNT_W) begin : g_bad_rep_w
      $error("tmr_timebase: REP_W must lie in 1..CNT_W");
   end

   ctrl_t            ctrl_q;
   logic [PSC_W-1:0] psc_buf, psc_act;
   logic [CNT_W-1:0] arr_buf, arr_act;
   logic [REP_W-1:0] rep_buf;
   logic             flag_q, uev_q;

   logic             run, cnt_step, cnt_wrap, rep_last;
   logic             uev_hw, uev_now;
   logic             wr_cnt, flag_clr;
   logic [CNT_W-1:0] arr_use, arr_refill, init_val;

   assign run        = ctrl_q.en && tick_en;
   assign wr_cnt     = wr_en && (wr_addr == RA_CNT);
   assign flag_clr   = wr_en && (wr_addr == RA_FLAG) && wr_data[0];
   assign arr_use    = ctrl_q.preload ? arr_act : arr_buf;
   assign arr_refill = rep_last ? arr_buf : arr_use;
   assign init_val   = (ctrl_q.mode == CM_DOWN) ? arr_buf : '0;
   assign uev_hw     = cnt_wrap && rep_last;
   assign uev_now    = uev_hw || sw_update;

   tmr_psc_div #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (sw_update),
      .div     (psc_act),
      .tick    (cnt_step)
   );

   tmr_cnt_core #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (cnt_step),
      .mode     (ctrl_q.mode),
      .limit    (arr_use),
      .refill   (arr_refill),
      .init     (sw_update),
      .init_val (init_val),
      .load     (wr_cnt),
      .load_val (wr_data),
      .count    (count),
      .wrap     (cnt_wrap)
   );

   if (REP_EN) begin : g_rep
      tmr_rep_div #(.REP_W(REP_W)) u_rep (
         .clk     (clk),
         .rst_n   (rst_n),
         .wrap    (cnt_wrap),
         .reload  (sw_update),
         .rep_val (rep_buf),
         .last    (rep_last)
      );
   end else begin : g_no_rep
      assign rep_last = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         psc_buf <= '0;
         psc_act <= '0;
         arr_buf <= '0;
         arr_act <= '0;
         rep_buf <= '0;
         flag_q  <= 1'b0;
         uev_q   <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               RA_CTRL:   ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
               RA_PSC:    psc_buf <= wr_data[PSC_W-1:0];
               RA_RELOAD: arr_buf <= wr_data;
               RA_REP:    rep_buf <= wr_data[REP_W-1:0];
               default:   ;
            endcase
         end
         if (uev_now) begin
            psc_act <= psc_buf;
            arr_act <= arr_buf;
         end
         if (uev_now)       flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         uev_q <= uev_now;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RA_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
         RA_PSC:    rd_data[PSC_W-1:0]  = psc_buf;
         RA_CNT:    rd_data             = count;
         RA_RELOAD: rd_data             = arr_buf;
         RA_REP:    rd_data[REP_W-1:0]  = rep_buf;
         RA_FLAG:   rd_data[0]          = flag_q;
         default:   rd_data             = '0;
      endcase
   end

   assign update_evt  = uev_q;
   assign update_flag = flag_q;
   assign irq         = flag_q && ctrl_q.ie;
endmodule

// File: rtl/tmr_timebase_chk.sv
`timescale 1ns/1ps
module tmr_timebase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_update,
   input logic             tick_en,
   input logic             ctrl_en,
   input logic             flag_clr,
   input logic             cnt_wr,
   input logic             update_evt,
   input logic             update_flag,
   input logic             irq,
   input logic [CNT_W-1:0] count
);
   // R2: idle time base keeps its count
   a_r2_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ctrl_en || !tick_en) && !sw_update && !cnt_wr) |=> $stable(count));

   // R2: no update pulse from an idle time base
   a_r2_no_idle_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ctrl_en || !tick_en) && !sw_update) |=> !update_evt);

   // R9: flag stays set until a clearing write
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (update_flag && !flag_clr) |=> update_flag);

   // R9: an update pulse is always accompanied by the flag
   a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      update_evt |-> update_flag);

   // R10: interrupt request never without the flag
   a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> update_flag);

   // R12: software request yields an update pulse next cycle
   a_r12_sw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sw_update |=> update_evt);
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_update   (sw_update),
   .tick_en     (tick_en),
   .ctrl_en     (ctrl_q.en),
   .flag_clr    (wr_en && (wr_addr == tmr_pkg::RA_FLAG) && wr_data[0]),
   .cnt_wr      (wr_en && (wr_addr == tmr_pkg::RA_CNT)),
   .update_evt  (update_evt),
   .update_flag (update_flag),
   .irq         (irq),
   .count       (count)
);

// File: tb/tb_tmr_timebase.sv
`timescale 1ns/1ps
module tb_tmr_timebase;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         sw_update = 1'b0;
   logic         update_evt, update_flag, irq;
   logic [W-1:0] count;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_timebase dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sw_update(sw_update),
      .update_evt(update_evt), .update_flag(update_flag), .irq(irq),
      .count(count)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [15:0] psc;
      logic [15:0] arr;
      logic [15:0] rep;
      logic [15:0] ticks;
      logic [15:0] exp_cnt;
      logic [7:0]  exp_upd;
   } vec_t;

   // mode 0 up, 1 down, 2 center
   localparam vec_t VEC [8] = '{
      '{2'd0, 16'd0, 16'd4, 16'd0, 16'd12, 16'd2, 8'd2},  // R4 up
      '{2'd0, 16'd2, 16'd3, 16'd0, 16'd20, 16'd2, 8'd1},  // R3 prescale 3
      '{2'd1, 16'd0, 16'd5, 16'd0, 16'd8,  16'd3, 8'd1},  // R5 down
      '{2'd1, 16'd1, 16'd2, 16'd0, 16'd15, 16'd1, 8'd2},  // R5 + R3
      '{2'd2, 16'd0, 16'd3, 16'd0, 16'd10, 16'd2, 8'd3},  // R6 center
      '{2'd0, 16'd0, 16'd1, 16'd2, 16'd13, 16'd1, 8'd2},  // R11 repeat 3
      '{2'd2, 16'd1, 16'd2, 16'd1, 16'd18, 16'd1, 8'd2},  // R6 + R11
      '{2'd0, 16'd3, 16'd0, 16'd0, 16'd8,  16'd0, 8'd2}   // R4 reload 0
   };

   function automatic logic [W-1:0] ctl(input logic [1:0] m, input logic en,
                                        input logic pre, input logic ie);
      return {11'd0, ie, pre, m, en};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic sw_pulse();
      @(negedge clk);
      sw_update = 1'b1;
      @(negedge clk);
      sw_update = 1'b0;
   endtask

   task automatic run(input int k, output int nupd);
      nupd = 0;
      tick_en = 1'b1;
      for (int i = 0; i < k; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (update_evt) nupd++;
      end
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v, n, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk($sformatf("R1 reg %0d", a), v, 0);
      end
      chk("R1 count", int'(count), 0);
      chk("R1 flag", int'(update_flag), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 event", int'(update_evt), 0);

      // table walk: R3 R4 R5 R6 R11
      for (int i = 0; i < 8; i++) begin
         wr(3'd1, VEC[i].psc);
         wr(3'd3, VEC[i].arr);
         wr(3'd4, VEC[i].rep);
         wr(3'd0, ctl(VEC[i].mode, 1'b0, 1'b0, 1'b0));
         sw_pulse();
         wr(3'd0, ctl(VEC[i].mode, 1'b1, 1'b0, 1'b0));
         run(int'(VEC[i].ticks), n);
         chk($sformatf("R3/R4/R5/R6/R11 vec %0d count", i), int'(count), int'(VEC[i].exp_cnt));
         chk($sformatf("R3/R4/R5/R6/R11 vec %0d updates", i), n, int'(VEC[i].exp_upd));
      end

      // R2: frozen when disabled, and when tick_en is low
      wr(3'd0, ctl(2'd0, 1'b0, 1'b0, 1'b0));
      c = int'(count);
      run(5, n);
      chk("R2 disabled count", int'(count), c);
      chk("R2 disabled updates", n, 0);
      wr(3'd0, ctl(2'd0, 1'b1, 1'b0, 1'b0));
      repeat (5) @(negedge clk);
      chk("R2 tick_en low count", int'(count), c);

      // R7: prescaler change waits for update
      wr(3'd1, 16'd0);
      wr(3'd3, 16'd7);
      wr(3'd4, 16'd0);
      sw_pulse();
      run(4, n);
      chk("R7 before change", int'(count), 4);
      wr(3'd1, 16'd3);
      run(4, n);
      chk("R7 old prescale to wrap", int'(count), 0);
      chk("R7 wrap update", n, 1);
      run(8, n);
      chk("R7 new prescale", int'(count), 2);

      // R8: reload without buffering
      wr(3'd1, 16'd0);
      wr(3'd3, 16'd10);
      sw_pulse();
      run(3, n);
      wr(3'd3, 16'd4);
      run(2, n);
      chk("R8 unbuffered count", int'(count), 0);
      chk("R8 unbuffered update", n, 1);
      // R8: reload with buffering
      wr(3'd3, 16'd10);
      wr(3'd0, ctl(2'd0, 1'b1, 1'b1, 1'b0));
      sw_pulse();
      run(3, n);
      wr(3'd3, 16'd4);
      run(2, n);
      chk("R8 buffered keeps old", int'(count), 5);
      chk("R8 buffered no update", n, 0);
      run(6, n);
      chk("R8 buffered old wrap", int'(count), 0);
      run(5, n);
      chk("R8 buffered new period", int'(count), 0);
      chk("R8 buffered new update", n, 1);

      // R9: sticky flag, write-one clear
      wr(3'd5, 16'd0);
      rd(3'd5, v);
      chk("R9 write 0 keeps flag", v, 1);
      wr(3'd5, 16'd1);
      rd(3'd5, v);
      chk("R9 write 1 clears flag", v, 0);

      // R10: masked interrupt
      sw_pulse();
      chk("R10 irq masked", int'(irq), 0);
      wr(3'd0, ctl(2'd0, 1'b1, 1'b1, 1'b1));
      chk("R10 irq enabled", int'(irq), 1);
      wr(3'd5, 16'd1);
      chk("R10 irq after clear", int'(irq), 0);

      // R12: software update in down mode
      wr(3'd0, ctl(2'd1, 1'b1, 1'b0, 1'b0));
      wr(3'd1, 16'd0);
      wr(3'd3, 16'd6);
      sw_pulse();
      run(5, n);
      chk("R12 pre-run down count", int'(count), 1);
      wr(3'd1, 16'd1);
      sw_pulse();
      chk("R12 update pulse", int'(update_evt), 1);
      chk("R12 count reinit", int'(count), 6);
      chk("R12 flag set", int'(update_flag), 1);
      run(4, n);
      chk("R12 prescaler loaded", int'(count), 4);

      // R13: direct counter write
      wr(3'd0, ctl(2'd0, 1'b1, 1'b0, 1'b0));
      wr(3'd1, 16'd0);
      sw_pulse();
      wr(3'd3, 16'd20);
      wr(3'd2, 16'd9);
      chk("R13 loaded count", int'(count), 9);
      rd(3'd2, v);
      chk("R13 read count", v, 9);
      run(3, n);
      chk("R13 continues", int'(count), 12);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule